// File: doc/BRIEF.md
# Hybrid Rectangle and Hashed Defect Map

This block answers, once per clock, whether a memory block address refers to a defective block. Defects are tracked at the granularity of an ECC-protected block, not per bit. Each query address is split into a row coordinate and a column coordinate over the block array. The memory controller beside it presents a lookup, and one cycle later it receives a registered verdict.

Two stores hold the defect information. A table of rectangular regions, all compared in parallel, covers clustered defects. A hashed bit vector covers scattered single blocks: inserting an address sets k bits chosen by k independent XOR-fold hashes, and a lookup hits only when all k bits are set. The vector is meant to be sized at roughly five bits per inserted defect. A block is reported defective when either store hits. False positives from the hashed store are acceptable. A block that was inserted, or that lies inside a valid rectangle, is never reported good.

A configuration port writes rectangle entries, inserts addresses into the hashed vector, and clears both stores. Configuration commands take precedence over a lookup presented in the same cycle.

Top module: `hybrid_defect_map`

## Requirements
- R1: After synchronous reset, `res_valid` and all result flags are 0, and lookups report no defect until something is written.
- R2: A lookup presented with `cfg_op` = 0 (no-op) produces `res_valid` = 1 exactly one cycle later, and `res_valid` is never 1 otherwise.
- R3: A valid rectangle entry matches when row_lo ≤ row ≤ row_hi and col_lo ≤ col ≤ col_hi, with both bounds inclusive; `res_rect_hit` is 1 exactly when some valid entry matches.
- R4: `cfg_op` = 1 writes the entry at `cfg_slot` with `cfg_rect_vld` and the four bounds, replacing its old contents; an entry written with `cfg_rect_vld` = 0 never matches.
- R5: `cfg_op` = 2 inserts the address (`cfg_row_lo`, `cfg_col_lo`) into the hashed vector; any later lookup of that address reports `res_hash_hit` = 1 until a clear or reset.
- R6: While no address has been inserted since the last reset or clear, `res_hash_hit` is 0 for every lookup.
- R7: `res_defect` equals `res_rect_hit` OR `res_hash_hit` for every valid result.
- R8: `cfg_op` = 3 invalidates every rectangle entry and zeroes the entire hashed vector.
- R9: A lookup presented in the same cycle as any nonzero `cfg_op` yields no result (`res_valid` = 0 the next cycle), and the configuration command still takes effect.
- R10: When `res_valid` is 0, `res_defect`, `res_rect_hit` and `res_hash_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_row | input | ROW_W | Lookup row coordinate |
| lk_col | input | COL_W | Lookup column coordinate |
| cfg_op | input | 2 | 0 no-op, 1 write rectangle, 2 insert address, 3 clear all |
| cfg_slot | input | SLOT_W | Rectangle entry index for a write |
| cfg_rect_vld | input | 1 | Valid bit written into the rectangle entry |
| cfg_row_lo | input | ROW_W | Rectangle lower row bound, or row of the inserted address |
| cfg_row_hi | input | ROW_W | Rectangle upper row bound |
| cfg_col_lo | input | COL_W | Rectangle lower column bound, or column of the inserted address |
| cfg_col_hi | input | COL_W | Rectangle upper column bound |
| res_valid | output | 1 | Registered result valid |
| res_defect | output | 1 | Block reported defective |
| res_rect_hit | output | 1 | A rectangle entry matched |
| res_hash_hit | output | 1 | All k hashed bits were set |

## Verification
A corrupted rectangle entry or a dropped hashed bit appears at the ports on the very next lookup that touches it. A lost bit shows as an inserted address whose `res_hash_hit` stays 0, a dead or stale entry as a wrong `res_rect_hit` on its boundary rows and columns, and both surface one cycle after the request. A missed clear shows as hits that persist after the command, and a hash mismatch between insert and lookup shows as a false negative on the first query of an inserted address. Boundary queries one step inside and one step outside each rectangle edge, mixed with random traffic, expose off-by-one compares in the same cycle the result is registered.

// File: rtl/defmap_pkg.sv
package defmap_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_RECT = 2'd1,
        OP_INS  = 2'd2,
        OP_CLR  = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic defect;
        logic rect_hit;
        logic hash_hit;
    } verdict_t;

    // Mask of address bits folded into index bit j of hash i.
    function automatic logic [31:0] fold_mask(int i, int j, int aw);
        logic [31:0] v;
        v = 32'h9E37_79B9 * 32'(i * 37 + j * 11 + 1);
        v = v ^ (v >> 13) ^ (v << 7);
        v = v | (32'd1 << ((i * 5 + j) % aw));
        return v;
    endfunction

endpackage

// File: rtl/dm_hash_unit.sv
module dm_hash_unit #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter int HASH_K = 3
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [HASH_K-1:0][IDX_W-1:0]  idx
);
    for (genvar i = 0; i < HASH_K; i++) begin : g_fn
        for (genvar j = 0; j < IDX_W; j++) begin : g_bit
            localparam logic [31:0] MASK = defmap_pkg::fold_mask(i, j, ADDR_W);
            assign idx[i][j] = ^(addr & MASK[ADDR_W-1:0]);
        end
    end
endmodule

// File: rtl/dm_bloom_vec.sv
module dm_bloom_vec #(
    parameter int IDX_W  = 10,
    parameter int HASH_K = 3,
    localparam int VEC_BITS = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          set_en,
    input  logic [HASH_K-1:0][IDX_W-1:0]  idx,
    output logic                          hit
);
    logic [VEC_BITS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (set_en) begin
            for (int i = 0; i < HASH_K; i++) begin
                bits_q[idx[i]] <= 1'b1;
            end
        end
    end

    always_comb begin
        hit = 1'b1;
        for (int i = 0; i < HASH_K; i++) begin
            hit = hit & bits_q[idx[i]];
        end
    end
endmodule

// File: rtl/dm_rect_table.sv
module dm_rect_table #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int RECT_N = 128,
    localparam int SLOT_W = $clog2(RECT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_vld,
    input  logic [ROW_W-1:0]  wr_row_lo,
    input  logic [ROW_W-1:0]  wr_row_hi,
    input  logic [COL_W-1:0]  wr_col_lo,
    input  logic [COL_W-1:0]  wr_col_hi,
    input  logic [ROW_W-1:0]  q_row,
    input  logic [COL_W-1:0]  q_col,
    output logic              hit
);
    logic [RECT_N-1:0] match;

    for (genvar e = 0; e < RECT_N; e++) begin : g_ent
        logic             vld_q;
        logic [ROW_W-1:0] rlo_q, rhi_q;
        logic [COL_W-1:0] clo_q, chi_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld_q <= 1'b0;
                rlo_q <= '0;
                rhi_q <= '0;
                clo_q <= '0;
                chi_q <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(e)) begin
                vld_q <= wr_vld;
                rlo_q <= wr_row_lo;
                rhi_q <= wr_row_hi;
                clo_q <= wr_col_lo;
                chi_q <= wr_col_hi;
            end
        end

        assign match[e] = vld_q
                        && (q_row >= rlo_q) && (q_row <= rhi_q)
                        && (q_col >= clo_q) && (q_col <= chi_q);
    end

    assign hit = |match;
endmodule

// File: rtl/hybrid_defect_map.sv
module hybrid_defect_map
    import defmap_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int RECT_N = 128,
    parameter int IDX_W  = 10,
    parameter int HASH_K = 3,
    localparam int SLOT_W = $clog2(RECT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic [COL_W-1:0]  lk_col,
    input  logic [1:0]        cfg_op,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_rect_vld,
    input  logic [ROW_W-1:0]  cfg_row_lo,
    input  logic [ROW_W-1:0]  cfg_row_hi,
    input  logic [COL_W-1:0]  cfg_col_lo,
    input  logic [COL_W-1:0]  cfg_col_hi,
    output logic              res_valid,
    output logic              res_defect,
    output logic              res_rect_hit,
    output logic              res_hash_hit
);
    localparam int ADDR_W = ROW_W + COL_W;

    cfg_op_e op;
    logic    do_rect, do_ins, do_clr, do_look;
    assign op      = cfg_op_e'(cfg_op);
    assign do_rect = (op == OP_RECT);
    assign do_ins  = (op == OP_INS);
    assign do_clr  = (op == OP_CLR);
    assign do_look = lk_valid && (op == OP_NOP);

    // One hash unit serves both insert and lookup: config wins the cycle.
    logic [ADDR_W-1:0]            hash_addr;
    logic [HASH_K-1:0][IDX_W-1:0] hash_idx;
    assign hash_addr = do_ins ? {cfg_row_lo, cfg_col_lo} : {lk_row, lk_col};

    dm_hash_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH_K(HASH_K)) hash_i (
        .addr (hash_addr),
        .idx  (hash_idx)
    );

    logic bloom_hit, rect_hit;

    dm_bloom_vec #(.IDX_W(IDX_W), .HASH_K(HASH_K)) bloom_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (do_clr),
        .set_en (do_ins),
        .idx    (hash_idx),
        .hit    (bloom_hit)
    );

    dm_rect_table #(.ROW_W(ROW_W), .COL_W(COL_W), .RECT_N(RECT_N)) rect_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (do_clr),
        .wr_en     (do_rect),
        .wr_slot   (cfg_slot),
        .wr_vld    (cfg_rect_vld),
        .wr_row_lo (cfg_row_lo),
        .wr_row_hi (cfg_row_hi),
        .wr_col_lo (cfg_col_lo),
        .wr_col_hi (cfg_col_hi),
        .q_row     (lk_row),
        .q_col     (lk_col),
        .hit       (rect_hit)
    );

    verdict_t verdict_d, verdict_q;
    logic     valid_q;

    always_comb begin
        verdict_d          = '0;
        verdict_d.rect_hit = do_look && rect_hit;
        verdict_d.hash_hit = do_look && bloom_hit;
        verdict_d.defect   = verdict_d.rect_hit || verdict_d.hash_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= do_look;
            verdict_q <= verdict_d;
        end
    end

    assign res_valid    = valid_q;
    assign res_defect   = verdict_q.defect;
    assign res_rect_hit = verdict_q.rect_hit;
    assign res_hash_hit = verdict_q.hash_hit;
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [ROW_W-1:0] lk_row,
    input logic [COL_W-1:0] lk_col,
    input logic [1:0]       cfg_op,
    input logic             cfg_rect_vld,
    input logic [ROW_W-1:0] cfg_row_lo,
    input logic [COL_W-1:0] cfg_col_lo,
    input logic             res_valid,
    input logic             res_defect,
    input logic             res_rect_hit,
    input logic             res_hash_hit
);
    logic                   hash_empty_q, rect_empty_q, have_ins_q;
    logic [ROW_W+COL_W-1:0] last_ins_q;

    always_ff @(posedge clk) begin
        if (rst || cfg_op == 2'd3) begin
            hash_empty_q <= 1'b1;
            rect_empty_q <= 1'b1;
            have_ins_q   <= 1'b0;
            last_ins_q   <= '0;
        end else begin
            if (cfg_op == 2'd2) begin
                hash_empty_q <= 1'b0;
                have_ins_q   <= 1'b1;
                last_ins_q   <= {cfg_row_lo, cfg_col_lo};
            end
            if (cfg_op == 2'd1 && cfg_rect_vld) rect_empty_q <= 1'b0;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg_op == 2'd0) |=> res_valid);

    assert_cfg_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_op != 2'd0) |=> !res_valid);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_defect || res_rect_hit || res_hash_hit));

    assert_either_store_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_defect == (res_rect_hit || res_hash_hit)));

    assert_empty_vec_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && hash_empty_q) |-> !res_hash_hit);

    assert_cleared_rects_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && rect_empty_q) |-> !res_rect_hit);

    assert_no_false_neg_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && have_ins_q && $past({lk_row, lk_col}) == last_ins_q) |-> res_hash_hit);
endmodule

bind hybrid_defect_map dm_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .lk_row       (lk_row),
    .lk_col       (lk_col),
    .cfg_op       (cfg_op),
    .cfg_rect_vld (cfg_rect_vld),
    .cfg_row_lo   (cfg_row_lo),
    .cfg_col_lo   (cfg_col_lo),
    .res_valid    (res_valid),
    .res_defect   (res_defect),
    .res_rect_hit (res_rect_hit),
    .res_hash_hit (res_hash_hit)
);

// File: tb/hybrid_defect_map_tb_top.sv
module hybrid_defect_map_tb_top;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 8;
    localparam int RECT_N = 128;
    localparam int SLOT_W = $clog2(RECT_N);
    localparam int MAXINS = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [ROW_W-1:0]  lk_row = '0;
    logic [COL_W-1:0]  lk_col = '0;
    logic [1:0]        cfg_op = 2'd0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic              cfg_rect_vld = 1'b0;
    logic [ROW_W-1:0]  cfg_row_lo = '0, cfg_row_hi = '0;
    logic [COL_W-1:0]  cfg_col_lo = '0, cfg_col_hi = '0;
    logic              res_valid, res_defect, res_rect_hit, res_hash_hit;

    always #4 clk = ~clk;

    hybrid_defect_map dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_row(lk_row), .lk_col(lk_col),
        .cfg_op(cfg_op), .cfg_slot(cfg_slot), .cfg_rect_vld(cfg_rect_vld),
        .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
        .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi),
        .res_valid(res_valid), .res_defect(res_defect),
        .res_rect_hit(res_rect_hit), .res_hash_hit(res_hash_hit)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench model
    bit        m_vld [RECT_N];
    int        m_rlo [RECT_N], m_rhi [RECT_N], m_clo [RECT_N], m_chi [RECT_N];
    int        ins_row [MAXINS], ins_col [MAXINS];
    int        ins_n = 0;

    logic s_valid, s_defect, s_rect, s_hash;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_rect(input int r, input int c);
        for (int e = 0; e < RECT_N; e++)
            if (m_vld[e] && r >= m_rlo[e] && r <= m_rhi[e] && c >= m_clo[e] && c <= m_chi[e])
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit was_inserted(input int r, input int c);
        for (int i = 0; i < ins_n; i++)
            if (ins_row[i] == r && ins_col[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_clear();
        for (int e = 0; e < RECT_N; e++) m_vld[e] = 1'b0;
        ins_n = 0;
    endtask

    task automatic wr_rect(input int slot, input bit v, input int rlo, input int rhi, input int clo, input int chi);
        @(negedge clk);
        cfg_op = 2'd1; cfg_slot = SLOT_W'(slot); cfg_rect_vld = v;
        cfg_row_lo = ROW_W'(rlo); cfg_row_hi = ROW_W'(rhi);
        cfg_col_lo = COL_W'(clo); cfg_col_hi = COL_W'(chi);
        m_vld[slot] = v; m_rlo[slot] = rlo; m_rhi[slot] = rhi; m_clo[slot] = clo; m_chi[slot] = chi;
        @(negedge clk);
        cfg_op = 2'd0;
    endtask

    task automatic ins(input int r, input int c);
        @(negedge clk);
        cfg_op = 2'd2; cfg_row_lo = ROW_W'(r); cfg_col_lo = COL_W'(c);
        if (ins_n < MAXINS) begin
            ins_row[ins_n] = r; ins_col[ins_n] = c; ins_n++;
        end
        @(negedge clk);
        cfg_op = 2'd0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        cfg_op = 2'd3;
        model_clear();
        @(negedge clk);
        cfg_op = 2'd0;
    endtask

    task automatic lookup(input int r, input int c);
        @(negedge clk);
        lk_valid = 1'b1; lk_row = ROW_W'(r); lk_col = COL_W'(c);
        @(negedge clk);
        lk_valid = 1'b0;
        s_valid = res_valid; s_defect = res_defect; s_rect = res_rect_hit; s_hash = res_hash_hit;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(!res_valid && !res_defect && !res_rect_hit && !res_hash_hit, "R1", "outputs after reset",
              {res_valid, res_defect, res_rect_hit, res_hash_hit}, 0);
        lookup(5, 7);
        check(s_valid && !s_defect, "R1", "empty map lookup defect", s_defect, 0);
        check(!s_hash, "R6", "empty vector hash hit", s_hash, 0);
        // R2 latency: valid exactly one cycle later, then drops
        check(s_valid == 1'b1, "R2", "valid one cycle after lookup", s_valid, 1);
        @(negedge clk);
        check(res_valid == 1'b0, "R2", "valid without lookup", res_valid, 0);
        // R10 flags zero when idle
        check(!res_defect && !res_rect_hit && !res_hash_hit, "R10", "flags while idle",
              {res_defect, res_rect_hit, res_hash_hit}, 0);

        // R3 inclusive bounds
        wr_rect(3, 1'b1, 10, 20, 30, 40);
        lookup(10, 30); check(s_rect == 1'b1, "R3", "corner lo/lo", s_rect, 1);
        lookup(20, 40); check(s_rect == 1'b1, "R3", "corner hi/hi", s_rect, 1);
        lookup(9, 35);  check(s_rect == 1'b0, "R3", "row below", s_rect, 0);
        lookup(21, 35); check(s_rect == 1'b0, "R3", "row above", s_rect, 0);
        lookup(15, 29); check(s_rect == 1'b0, "R3", "col below", s_rect, 0);
        lookup(15, 41); check(s_rect == 1'b0, "R3", "col above", s_rect, 0);
        lookup(15, 35); check(s_defect == 1'b1 && !s_hash, "R7", "defect from rect only", s_defect, 1);

        // R4 overwrite and invalid entry
        wr_rect(3, 1'b1, 50, 50, 60, 60);
        lookup(15, 35); check(s_rect == 1'b0, "R4", "old region replaced", s_rect, 0);
        lookup(50, 60); check(s_rect == 1'b1, "R4", "new single-cell region", s_rect, 1);
        wr_rect(3, 1'b0, 50, 50, 60, 60);
        lookup(50, 60); check(s_rect == 1'b0, "R4", "invalid entry ignored", s_rect, 0);

        // R5 inserts never miss
        ins(200, 17); ins(0, 0); ins(255, 255);
        lookup(200, 17); check(s_hash == 1'b1, "R5", "inserted 200/17", s_hash, 1);
        check(s_defect == 1'b1 && !s_rect, "R7", "defect from hash only", s_defect, 1);
        lookup(0, 0);     check(s_hash == 1'b1, "R5", "inserted 0/0", s_hash, 1);
        lookup(255, 255); check(s_hash == 1'b1, "R5", "inserted 255/255", s_hash, 1);

        // R9 config beats same-cycle lookup, command still applied
        @(negedge clk);
        cfg_op = 2'd1; cfg_slot = SLOT_W'(7); cfg_rect_vld = 1'b1;
        cfg_row_lo = 8'd100; cfg_row_hi = 8'd100; cfg_col_lo = 8'd100; cfg_col_hi = 8'd100;
        m_vld[7] = 1'b1; m_rlo[7] = 100; m_rhi[7] = 100; m_clo[7] = 100; m_chi[7] = 100;
        lk_valid = 1'b1; lk_row = 8'd100; lk_col = 8'd100;
        @(negedge clk);
        cfg_op = 2'd0; lk_valid = 1'b0;
        check(res_valid == 1'b0, "R9", "lookup dropped under config", res_valid, 0);
        lookup(100, 100); check(s_rect == 1'b1, "R9", "config applied", s_rect, 1);

        // R8 clear wipes both stores
        clear_all();
        lookup(100, 100); check(s_rect == 1'b0, "R8", "rect after clear", s_rect, 0);
        lookup(200, 17);  check(s_hash == 1'b0 && !s_defect, "R8", "hash after clear", s_hash, 0);

        // Random mix
        for (int e = 0; e < 6; e++) begin
            int rl, cl;
            rl = int'($urandom_range(0, 230));
            cl = int'($urandom_range(0, 230));
            wr_rect(int'($urandom_range(0, RECT_N - 1)), 1'b1, rl, rl + int'($urandom_range(0, 24)),
                    cl, cl + int'($urandom_range(0, 24)));
        end
        for (int i = 0; i < 20; i++)
            ins(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        for (int n = 0; n < 300; n++) begin
            int r, c;
            bit er;
            if (n % 2 == 0) begin
                int k;
                k = int'($urandom_range(0, ins_n - 1));
                r = ins_row[k]; c = ins_col[k];
            end else begin
                r = int'($urandom_range(0, 255)); c = int'($urandom_range(0, 255));
            end
            lookup(r, c);
            er = exp_rect(r, c);
            check(s_valid && s_rect == er, "R3", "random rect match", s_rect, er);
            if (was_inserted(r, c))
                check(s_hash == 1'b1, "R5", "random inserted hit", s_hash, 1);
            check(s_defect == (s_rect | s_hash), "R7", "random defect OR", s_defect, s_rect | s_hash);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule